// File: doc/BRIEF.md
# Stack Call and Return Sequencer

This block runs the stack side of a small 8-bit processor core. It keeps the stack pointer and drives a byte-wide stack memory. From one command strobe it runs a short sequence of memory cycles. The commands are: push a byte, pop a byte, call a subroutine, return from a subroutine, and return from an interrupt. The core supplies the operands with the strobe: a data byte, the current 16-bit program counter, the flags byte and a call target. The core receives a popped byte, a new program counter and a restored flags byte. Load strobes come with the done pulse.

The memory port issues at most one request per cycle. A read returns its data in the cycle after the request. A write takes effect at the clock edge that ends the request cycle. Every sequence is built from a few micro-steps:
- decrement the pointer;
- write at the pointer;
- read at the pointer;
- capture the read byte and increment the pointer;
- finish.

The pointer always moves down before a write and up after a read. This makes the stack grow downward. The pointer wraps at the ends of the address space.

Top module: `stack_seq`

## Requirements
- R1: After reset, sp is 0, busy and done are 0, pc_out and flags_out are 0, and no memory request is issued.
- R2: Command code 1 (push) first decrements sp by one. In a later cycle it writes the push_data captured at the strobe to the decremented address. The net sp change is -1.
- R3: Command code 2 (pop) reads the byte at sp. The byte is presented on pop_data during the done cycle. sp is incremented only after the read, for a net change of +1.
- R4: Command code 3 (call) pushes pc_in as two bytes, low byte first at sp-1 and high byte second at sp-2. It then presents call_target on pc_out with pc_load high during the done cycle. The net sp change is -2.
- R5: Command code 4 (return) reads the high byte at sp, then the low byte at sp+1. It presents the 16-bit value on pc_out with pc_load high during the done cycle. The net sp change is +2.
- R6: Command code 5 (return from interrupt) first reads the flags byte at sp. It then restores the program counter as in R5 from the next two addresses. It presents flags_out with flags_load and pc_out with pc_load during the done cycle. The net sp change is +3.
- R7: busy rises in the cycle after an accepted strobe and stays high through a done pulse of exactly one cycle. busy is low in the cycle after done. Strobes while busy is high are ignored.
- R8: Command codes 0, 6 and 7 are ignored: busy stays low and sp is unchanged.
- R9: The byte returned on mem_rdata in the cycle after a read request is the one captured. At most one memory request is issued per cycle.
- R10: sp wraps modulo 256: a decrement from 0 gives 255 and an increment from 255 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, accepted when busy is low |
| cmd_op | input | 3 | Command code: 1 push, 2 pop, 3 call, 4 return, 5 interrupt return |
| push_data | input | 8 | Byte to push |
| pc_in | input | 16 | Current program counter, saved by call |
| call_target | input | 16 | Address loaded by call |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sp | output | 8 | Stack pointer |
| pop_data | output | 8 | Popped byte, valid at done of a pop |
| pc_out | output | 16 | New program counter, valid with pc_load |
| pc_load | output | 1 | Program counter load strobe, high only at done |
| flags_out | output | 8 | Restored flags byte, valid with flags_load |
| flags_load | output | 1 | Flags load strobe, high only at done |
| mem_req | output | 1 | Stack memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 8 | Stack memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after the read request |

## Verification
A pointer updated on the wrong side of a memory access moves every byte of a frame by one address. This shows up at the done pulse of the first pop, return or call that follows: a wrong byte on pop_data or pc_out, or a wrong byte found in the stack memory. Swapped byte order in a call or a return corrupts pc_out at the done of that return. A return from interrupt that reads flags in the wrong position corrupts both flags_out and pc_out in its own done cycle. A sequencer that skips, repeats or re-accepts a step is caught by the done count against commands issued, and by the pointer value compared at every done.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4,
        OP_IRET = 3'd5
    } op_e;

    typedef enum logic [3:0] {
        U_IDLE,
        U_DEC,
        U_WR_DATA,
        U_WR_PCLO,
        U_WR_PCHI,
        U_RD,
        U_CAP_DATA,
        U_CAP_PCHI,
        U_CAP_PCLO,
        U_CAP_FLAGS,
        U_FIN
    } uop_e;

    localparam int STEP_W = 3;

    function automatic logic op_legal(input logic [2:0] raw);
        return (raw >= 3'd1) && (raw <= 3'd5);
    endfunction

    // Micro-program: pointer moves down before a write and up after a read.
    function automatic uop_e program_step(input op_e op, input logic [STEP_W-1:0] step);
        uop_e u;
        u = U_FIN;
        case (op)
            OP_PUSH: begin
                case (step)
                    3'd0:    u = U_DEC;
                    3'd1:    u = U_WR_DATA;
                    default: u = U_FIN;
                endcase
            end
            OP_POP: begin
                case (step)
                    3'd0:    u = U_RD;
                    3'd1:    u = U_CAP_DATA;
                    default: u = U_FIN;
                endcase
            end
            OP_CALL: begin
                case (step)
                    3'd0:    u = U_DEC;
                    3'd1:    u = U_WR_PCLO;
                    3'd2:    u = U_DEC;
                    3'd3:    u = U_WR_PCHI;
                    default: u = U_FIN;
                endcase
            end
            OP_RET: begin
                case (step)
                    3'd0:    u = U_RD;
                    3'd1:    u = U_CAP_PCHI;
                    3'd2:    u = U_RD;
                    3'd3:    u = U_CAP_PCLO;
                    default: u = U_FIN;
                endcase
            end
            OP_IRET: begin
                case (step)
                    3'd0:    u = U_RD;
                    3'd1:    u = U_CAP_FLAGS;
                    3'd2:    u = U_RD;
                    3'd3:    u = U_CAP_PCHI;
                    3'd4:    u = U_RD;
                    3'd5:    u = U_CAP_PCLO;
                    default: u = U_FIN;
                endcase
            end
            default: u = U_FIN;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
    import stack_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    output logic       accept,
    output logic       busy,
    output logic       done,
    output uop_e       uop,
    output op_e        op
);

    typedef struct packed {
        logic              run;
        op_e               op;
        logic [STEP_W-1:0] step;
    } ctrl_t;

    ctrl_t st_d, st_q;

    assign uop    = st_q.run ? program_step(st_q.op, st_q.step) : U_IDLE;
    assign accept = !st_q.run && cmd_valid && op_legal(cmd_op);
    assign busy   = st_q.run;
    assign done   = st_q.run && (uop == U_FIN);
    assign op     = st_q.op;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.run  = 1'b1;
            st_d.op   = op_e'(cmd_op);
            st_d.step = '0;
        end else if (st_q.run) begin
            if (uop == U_FIN) begin
                st_d.run  = 1'b0;
                st_d.step = '0;
            end else begin
                st_d.step = st_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{run: 1'b0, op: OP_NONE, step: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/stack_seq_ptr.sv
module stack_seq_ptr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec,
    input  logic              inc,
    output logic [ADDR_W-1:0] sp
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] sp;
    } ptr_t;

    ptr_t p_d, p_q;

    assign sp = p_q.sp;

    // Natural ADDR_W-bit arithmetic wraps modulo 2**ADDR_W.
    always_comb begin
        p_d = p_q;
        if (dec) begin
            p_d.sp = p_q.sp - ONE;
        end else if (inc) begin
            p_d.sp = p_q.sp + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '{sp: '0};
        end else begin
            p_q <= p_d;
        end
    end

endmodule

// File: rtl/stack_seq_dp.sv
module stack_seq_dp
    import stack_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    localparam int PC_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  uop_e              uop,
    input  op_e               op,
    input  logic [ADDR_W-1:0] sp,
    input  logic [DATA_W-1:0] push_data,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [PC_W-1:0]   call_target,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] pop_data,
    output logic [PC_W-1:0]   pc_out,
    output logic              pc_load,
    output logic [DATA_W-1:0] flags_out,
    output logic              flags_load
);

    typedef struct packed {
        logic [DATA_W-1:0] push_byte;
        logic [PC_W-1:0]   pc_save;
        logic [PC_W-1:0]   target;
        logic [DATA_W-1:0] hold_hi;
        logic [DATA_W-1:0] pop_byte;
        logic [PC_W-1:0]   pc;
        logic [DATA_W-1:0] flags;
    } dp_t;

    dp_t r_d, r_q;

    logic is_wr, is_rd;

    assign is_wr = (uop == U_WR_DATA) || (uop == U_WR_PCLO) || (uop == U_WR_PCHI);
    assign is_rd = (uop == U_RD);

    assign mem_req  = is_wr || is_rd;
    assign mem_we   = is_wr;
    assign mem_addr = sp;

    always_comb begin
        case (uop)
            U_WR_PCLO: mem_wdata = r_q.pc_save[DATA_W-1:0];
            U_WR_PCHI: mem_wdata = r_q.pc_save[PC_W-1:DATA_W];
            default:   mem_wdata = r_q.push_byte;
        endcase
    end

    assign pop_data   = r_q.pop_byte;
    assign pc_out     = r_q.pc;
    assign flags_out  = r_q.flags;
    assign pc_load    = (uop == U_FIN) &&
                        ((op == OP_CALL) || (op == OP_RET) || (op == OP_IRET));
    assign flags_load = (uop == U_FIN) && (op == OP_IRET);

    always_comb begin
        r_d = r_q;
        if (accept) begin
            r_d.push_byte = push_data;
            r_d.pc_save   = pc_in;
            r_d.target    = call_target;
        end
        case (uop)
            U_WR_PCHI:   r_d.pc       = r_q.target;
            U_CAP_DATA:  r_d.pop_byte = mem_rdata;
            U_CAP_FLAGS: r_d.flags    = mem_rdata;
            U_CAP_PCHI:  r_d.hold_hi  = mem_rdata;
            U_CAP_PCLO:  r_d.pc       = {r_q.hold_hi, mem_rdata};
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stack_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    localparam int PC_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] push_data,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [PC_W-1:0]   call_target,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] sp,
    output logic [DATA_W-1:0] pop_data,
    output logic [PC_W-1:0]   pc_out,
    output logic              pc_load,
    output logic [DATA_W-1:0] flags_out,
    output logic              flags_load,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic accept;
    uop_e uop;
    op_e  op;
    logic sp_dec, sp_inc;

    assign sp_dec = (uop == U_DEC);
    assign sp_inc = (uop == U_CAP_DATA) || (uop == U_CAP_PCHI) ||
                    (uop == U_CAP_PCLO) || (uop == U_CAP_FLAGS);

    stack_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .accept    (accept),
        .busy      (busy),
        .done      (done),
        .uop       (uop),
        .op        (op)
    );

    stack_seq_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .dec   (sp_dec),
        .inc   (sp_inc),
        .sp    (sp)
    );

    stack_seq_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .uop         (uop),
        .op          (op),
        .sp          (sp),
        .push_data   (push_data),
        .pc_in       (pc_in),
        .call_target (call_target),
        .mem_rdata   (mem_rdata),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .pop_data    (pop_data),
        .pc_out      (pc_out),
        .pc_load     (pc_load),
        .flags_out   (flags_out),
        .flags_load  (flags_load)
    );

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] sp,
    input logic              mem_req,
    input logic              mem_we,
    input logic              pc_load,
    input logic              flags_load
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R7
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R7
    AST_WRITE_AFTER_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (sp == ($past(sp) - ONE))); // R2
    AST_READ_HOLDS_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> $stable(sp)); // R3
    AST_INC_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_req && !mem_we, 2) |-> (sp == ($past(sp, 2) + ONE))); // R3
    AST_SP_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(sp)); // R8
    AST_LOADS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load || flags_load) |-> done); // R4
    AST_FLAGS_WITH_PC: assert property (@(posedge clk) disable iff (!rst_n)
        flags_load |-> pc_load); // R6
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R9

endmodule

bind stack_seq stack_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .sp         (sp),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .pc_load    (pc_load),
    .flags_load (flags_load)
);

// File: tb/stack_seq_tb.sv
`timescale 1ns/1ps
module stack_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [7:0]  push_data = 8'h00;
    logic [15:0] pc_in = 16'h0000;
    logic [15:0] call_target = 16'h0000;
    logic        busy, done, pc_load, flags_load, mem_req, mem_we;
    logic [7:0]  sp, pop_data, flags_out, mem_addr, mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] pc_out;

    always #2.5 clk = ~clk;

    stack_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .push_data(push_data), .pc_in(pc_in), .call_target(call_target),
        .busy(busy), .done(done), .sp(sp), .pop_data(pop_data),
        .pc_out(pc_out), .pc_load(pc_load), .flags_out(flags_out),
        .flags_load(flags_load), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Stack memory: one-cycle read latency (R9).
    logic [7:0] ram  [256];
    logic [7:0] mram [256];
    logic [7:0] msp = 8'h00;

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        mem_rdata     <= ram[mem_addr];
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    int n_issued = 0;
    int n_done = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct {
        int         op;
        string      req;
        logic [7:0] pop;
        logic [15:0] pc;
        logic [7:0] fl;
        logic [7:0] spv;
    } exp_t;

    exp_t exp_q[$];

    // Monitor: compare at every done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_done++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(sp == e.spv, {e.req, " sp"}, sp, e.spv);
                if (e.op == 2) chk(pop_data == e.pop, {e.req, " pop_data"}, pop_data, e.pop);
                if (e.op >= 3) begin
                    chk(pc_load == 1'b1, {e.req, " pc_load"}, pc_load, 1);
                    chk(pc_out == e.pc, {e.req, " pc_out"}, pc_out, e.pc);
                end else begin
                    chk(pc_load == 1'b0, {e.req, " pc_load idle"}, pc_load, 0);
                end
                if (e.op == 5) begin
                    chk(flags_load == 1'b1, {e.req, " flags_load"}, flags_load, 1);
                    chk(flags_out == e.fl, {e.req, " flags_out"}, flags_out, e.fl);
                end else begin
                    chk(flags_load == 1'b0, {e.req, " flags_load idle"}, flags_load, 0);
                end
            end
        end
    end

    // Driver: computes expectations from the requirements, then runs the command.
    task automatic issue(input int op, input logic [7:0] d, input logic [15:0] pc,
                         input logic [15:0] tgt, input string req, input bit hold);
        exp_t e;
        logic [7:0] hi, lo;
        e.op = op; e.req = req; e.pop = 8'h00; e.pc = 16'h0000; e.fl = 8'h00;
        case (op)
            1: begin msp = msp - 8'd1; mram[msp] = d; end
            2: begin e.pop = mram[msp]; msp = msp + 8'd1; end
            3: begin
                msp = msp - 8'd1; mram[msp] = pc[7:0];
                msp = msp - 8'd1; mram[msp] = pc[15:8];
                e.pc = tgt;
            end
            default: begin
                if (op == 5) begin e.fl = mram[msp]; msp = msp + 8'd1; end
                hi = mram[msp]; msp = msp + 8'd1;
                lo = mram[msp]; msp = msp + 8'd1;
                e.pc = {hi, lo};
            end
        endcase
        e.spv = msp;
        exp_q.push_back(e);
        n_issued++;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); push_data = d; pc_in = pc; call_target = tgt;
        @(negedge clk);
        chk(busy == 1'b1, "R7 busy after strobe", busy, 1);
        if (hold) begin
            cmd_op = 3'd1; push_data = 8'hEE;
        end else begin
            cmd_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R7 busy low after done", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i]  = 8'(i) ^ 8'h5A;
            mram[i] = 8'(i) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sp == 8'h00, "R1 sp reset", sp, 0);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done reset", {busy, done}, 0);
        chk(pc_out == 16'h0 && flags_out == 8'h0, "R1 outputs reset", pc_out, 0);
        chk(mem_req == 1'b0, "R1 no request", mem_req, 0);

        issue(1, 8'hA5, 16'h0, 16'h0, "R2 R10 push wrap", 1'b0);
        chk(ram[8'hFF] == 8'hA5, "R2 push stored at 255", ram[8'hFF], 8'hA5);
        issue(1, 8'h3C, 16'h0, 16'h0, "R2 push", 1'b0);
        chk(ram[8'hFE] == 8'h3C, "R2 push stored at 254", ram[8'hFE], 8'h3C);
        issue(2, 8'h00, 16'h0, 16'h0, "R3 R9 pop", 1'b0);

        issue(3, 8'h00, 16'h1234, 16'hABCD, "R4 call", 1'b0);
        chk(ram[8'hFE] == 8'h34, "R4 low byte first", ram[8'hFE], 8'h34);
        chk(ram[8'hFD] == 8'h12, "R4 high byte second", ram[8'hFD], 8'h12);
        issue(4, 8'h00, 16'h0, 16'h0, "R5 return", 1'b0);

        issue(3, 8'h00, 16'hBEEF, 16'h0040, "R4 call frame", 1'b0);
        issue(1, 8'hC3, 16'h0, 16'h0, "R2 push flags", 1'b0);
        issue(5, 8'h00, 16'h0, 16'h0, "R6 interrupt return", 1'b0);

        issue(2, 8'h00, 16'h0, 16'h0, "R10 pop wrap 255", 1'b0);
        chk(sp == 8'h00, "R10 sp wrapped to 0", sp, 0);
        issue(2, 8'h00, 16'h0, 16'h0, "R3 pop unwritten", 1'b0);

        issue(1, 8'h77, 16'h0, 16'h0, "R7 push with strobe held", 1'b1);
        chk(sp == 8'h00, "R7 held strobe ignored sp", sp, 0);
        chk(ram[8'hFF] == 8'hA5, "R7 held strobe no write", ram[8'hFF], 8'hA5);

        for (int c = 6; c <= 8; c++) begin
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 3'(c & 7);
            @(negedge clk);
            cmd_valid = 1'b0;
            @(negedge clk);
            chk(busy == 1'b0, "R8 illegal code no busy", busy, 0);
            chk(sp == msp, "R8 illegal code sp", sp, msp);
        end

        for (int k = 0; k < 3; k++)
            issue(1, 8'(8'h90 + k), 16'h0, 16'h0, "R2 push series", 1'b0);
        issue(3, 8'h00, 16'h00FF, 16'hFFFF, "R4 call top target", 1'b0);
        issue(5, 8'h00, 16'h0, 16'h0, "R6 interrupt return mixed", 1'b0);
        issue(4, 8'h00, 16'h0, 16'h0, "R5 return mixed", 1'b0);

        repeat (2) @(negedge clk);
        chk(n_done == n_issued, "R7 done count", n_done, n_issued);
        chk(exp_q.size() == 0, "R7 scoreboard empty", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL R7 watchdog actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule